// File: doc/BRIEF.md
# Per-Load Stride Predictor

This block decides, for each data access that misses both the data cache and every stream buffer, whether a stream buffer should be started and with what stride. The decision rests only on the miss history of the static load that caused the miss. A fully associative table, keyed by the load's program-counter value, holds for each tracked load its most recent miss address, the most recent address difference, and a two-state history marker.

A load not present in the table gets an entry, and a buffer starts at once with a positive unit stride. The load's second miss only records the difference. From the third miss on, a buffer starts only when the new difference equals the stored one. That difference becomes the stride, except that any stride shorter than one cache block is widened to one block with the same sign. When the table is full, a new load takes the place of the least recently used entry. Every decision appears on a registered output strobe one cycle after the miss, together with the signed stride and the address of the first block to prefetch.

Top module: `stride_predictor`

## Requirements
- R1: After reset the allocate strobe is low and the table is empty, so the first miss from any PC is handled as a new load.
- R2: A miss whose PC is not in the table raises the allocate strobe exactly one cycle later, with stride +BLOCK_BYTES and start address equal to the miss address plus BLOCK_BYTES.
- R3: The second miss from a tracked PC never raises the allocate strobe. It records the difference between its address and the previous one.
- R4: On the third and later misses from a PC, the strobe rises one cycle later if and only if the new address difference (modulo 2^ADDR_W, read as signed) equals the previously stored one. The start address is then the miss address plus the output stride.
- R5: A confirmed difference whose magnitude is below BLOCK_BYTES is output as +BLOCK_BYTES when it is zero or positive, and as -BLOCK_BYTES when it is negative. Larger differences are output unchanged.
- R6: Each PC's history evolves independently of misses from other PCs that stay in the table.
- R7: When all DEPTH entries are in use, a miss from a new PC replaces the least recently missing PC. A later miss from the evicted PC is treated as a new load (R2).
- R8: The allocate strobe is high only in the cycle after a cycle with a valid miss, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | A miss event is present this cycle |
| miss_pc_i | input | PC_W | Program counter of the missing load |
| miss_addr_i | input | ADDR_W | Byte address of the missing access |
| alloc_o | output | 1 | Start a stream buffer (one-cycle strobe) |
| alloc_addr_o | output | ADDR_W | First block address to prefetch |
| alloc_stride_o | output | ADDR_W | Signed stride in bytes (two's complement) |

## Verification
A corrupted stored difference or history state shows up at the ports at that PC's next miss: an allocation appears where none is due, one is missing, or the stride is wrong. A wrong recency order stays hidden until the table overflows. It then shows as a spurious unit-stride allocation for a PC that should still be tracked, or as a missing one for a PC that should have been evicted. The bench therefore mixes many PCs with repeated evictions and keeps its own timestamp-based model of recency.

// File: rtl/stride_pkg.sv
package stride_pkg;
  typedef enum logic [0:0] {
    HIST_FIRST = 1'b0,
    HIST_READY = 1'b1
  } hist_e;
endpackage

// File: rtl/stride_lru.sv
module stride_lru #(
  parameter int unsigned DEPTH = 10,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] victim_idx_o,
  output logic [DEPTH-1:0] oldest_vec_o
);
  logic [IDX_W-1:0] age_q [DEPTH];
  logic [IDX_W-1:0] touch_age;

  assign touch_age = age_q[touch_idx_i];

  // ages form a permutation of 0..DEPTH-1; untouched slots drift to the top
  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[g] <= IDX_W'(g);
      end else if (touch_i) begin
        if (touch_idx_i == IDX_W'(g))   age_q[g] <= '0;
        else if (age_q[g] < touch_age)  age_q[g] <= age_q[g] + 1'b1;
      end
    end
    assign oldest_vec_o[g] = (age_q[g] == IDX_W'(DEPTH - 1));
  end

  always_comb begin
    victim_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (oldest_vec_o[i]) victim_idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/stride_table.sv
module stride_table
  import stride_pkg::*;
#(
  parameter int unsigned DEPTH  = 10,
  parameter int unsigned PC_W   = 32,
  parameter int unsigned ADDR_W = 32,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   lookup_pc_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  hit_idx_o,
  output logic [DEPTH-1:0]  match_vec_o,
  output logic [ADDR_W-1:0] hit_last_o,
  output logic [ADDR_W-1:0] hit_delta_o,
  output hist_e             hit_state_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [PC_W-1:0]   wr_pc_i,
  input  logic [ADDR_W-1:0] wr_last_i,
  input  logic [ADDR_W-1:0] wr_delta_i,
  input  hist_e             wr_state_i
);
  logic              vld_q   [DEPTH];
  logic [PC_W-1:0]   pc_q    [DEPTH];
  logic [ADDR_W-1:0] last_q  [DEPTH];
  logic [ADDR_W-1:0] delta_q [DEPTH];
  hist_e             state_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]   <= 1'b0;
        pc_q[g]    <= '0;
        last_q[g]  <= '0;
        delta_q[g] <= '0;
        state_q[g] <= HIST_FIRST;
      end else if (wr_en_i && wr_idx_i == IDX_W'(g)) begin
        vld_q[g]   <= 1'b1;
        pc_q[g]    <= wr_pc_i;
        last_q[g]  <= wr_last_i;
        delta_q[g] <= wr_delta_i;
        state_q[g] <= wr_state_i;
      end
    end
    assign match_vec_o[g] = vld_q[g] && (pc_q[g] == lookup_pc_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match_vec_o[i]) hit_idx_o = IDX_W'(i);
    end
  end

  assign hit_o       = |match_vec_o;
  assign hit_last_o  = last_q[hit_idx_o];
  assign hit_delta_o = delta_q[hit_idx_o];
  assign hit_state_o = state_q[hit_idx_o];
endmodule

// File: rtl/stride_decide.sv
module stride_decide
  import stride_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BLOCK_BYTES = 32
) (
  input  logic              hit_i,
  input  hist_e             state_i,
  input  logic [ADDR_W-1:0] last_i,
  input  logic [ADDR_W-1:0] prev_delta_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              alloc_o,
  output logic [ADDR_W-1:0] stride_o,
  output logic [ADDR_W-1:0] new_delta_o,
  output hist_e             new_state_o
);
  localparam logic signed [ADDR_W-1:0] BLK  = ADDR_W'(BLOCK_BYTES);
  localparam logic signed [ADDR_W-1:0] NBLK = -BLK;

  logic signed [ADDR_W-1:0] delta;
  logic signed [ADDR_W-1:0] clamped;

  assign delta = addr_i - last_i;

  always_comb begin
    if (delta > NBLK && delta < BLK) clamped = delta[ADDR_W-1] ? NBLK : BLK;
    else                             clamped = delta;
  end

  always_comb begin
    alloc_o     = 1'b0;
    stride_o    = BLK;
    new_delta_o = '0;
    new_state_o = HIST_FIRST;
    if (!hit_i) begin
      alloc_o = 1'b1;
    end else if (state_i == HIST_FIRST) begin
      new_delta_o = delta;
      new_state_o = HIST_READY;
    end else begin
      alloc_o     = (delta == prev_delta_i);
      stride_o    = clamped;
      new_delta_o = delta;
      new_state_o = HIST_READY;
    end
  end
endmodule

// File: rtl/stride_predictor.sv
module stride_predictor
  import stride_pkg::*;
#(
  parameter int unsigned PC_W        = 32,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DEPTH       = 10,
  parameter int unsigned BLOCK_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              miss_valid_i,
  input  logic [PC_W-1:0]   miss_pc_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  output logic              alloc_o,
  output logic [ADDR_W-1:0] alloc_addr_o,
  output logic [ADDR_W-1:0] alloc_stride_o
);
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [IDX_W-1:0]  victim_idx;
  logic [IDX_W-1:0]  wr_idx;
  logic [DEPTH-1:0]  match_vec;
  logic [DEPTH-1:0]  oldest_vec;
  logic [ADDR_W-1:0] hit_last;
  logic [ADDR_W-1:0] hit_delta;
  hist_e             hit_state;
  logic              dec_alloc;
  logic [ADDR_W-1:0] dec_stride;
  logic [ADDR_W-1:0] dec_delta;
  hist_e             dec_state;

  assign wr_idx = hit ? hit_idx : victim_idx;

  stride_table #(.DEPTH(DEPTH), .PC_W(PC_W), .ADDR_W(ADDR_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lookup_pc_i (miss_pc_i),
    .hit_o       (hit),
    .hit_idx_o   (hit_idx),
    .match_vec_o (match_vec),
    .hit_last_o  (hit_last),
    .hit_delta_o (hit_delta),
    .hit_state_o (hit_state),
    .wr_en_i     (miss_valid_i),
    .wr_idx_i    (wr_idx),
    .wr_pc_i     (miss_pc_i),
    .wr_last_i   (miss_addr_i),
    .wr_delta_i  (dec_delta),
    .wr_state_i  (dec_state)
  );

  stride_lru #(.DEPTH(DEPTH)) u_lru (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .touch_i      (miss_valid_i),
    .touch_idx_i  (wr_idx),
    .victim_idx_o (victim_idx),
    .oldest_vec_o (oldest_vec)
  );

  stride_decide #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_decide (
    .hit_i        (hit),
    .state_i      (hit_state),
    .last_i       (hit_last),
    .prev_delta_i (hit_delta),
    .addr_i       (miss_addr_i),
    .alloc_o      (dec_alloc),
    .stride_o     (dec_stride),
    .new_delta_o  (dec_delta),
    .new_state_o  (dec_state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alloc_o        <= 1'b0;
      alloc_addr_o   <= '0;
      alloc_stride_o <= '0;
    end else begin
      alloc_o <= miss_valid_i && dec_alloc;
      if (miss_valid_i && dec_alloc) begin
        alloc_addr_o   <= miss_addr_i + dec_stride;
        alloc_stride_o <= dec_stride;
      end
    end
  end
endmodule

// File: rtl/stride_predictor_chk.sv
module stride_predictor_chk #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned DEPTH       = 10,
  parameter int unsigned BLOCK_BYTES = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              miss_valid_i,
  input logic [ADDR_W-1:0] miss_addr_i,
  input logic              alloc_o,
  input logic [ADDR_W-1:0] alloc_addr_o,
  input logic [ADDR_W-1:0] alloc_stride_o,
  input logic [DEPTH-1:0]  match_vec,
  input logic [DEPTH-1:0]  oldest_vec
);
  localparam logic signed [ADDR_W-1:0] BLK = ADDR_W'(BLOCK_BYTES);

  a_r8_alloc_after_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_o |-> $past(miss_valid_i));

  a_r5_stride_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_o |-> ($signed(alloc_stride_o) >= BLK || $signed(alloc_stride_o) <= -BLK));

  a_r4_start_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_o |-> alloc_addr_o == $past(miss_addr_i) + alloc_stride_o);

  a_r6_unique_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));

  a_r7_single_oldest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(oldest_vec));
endmodule

bind stride_predictor stride_predictor_chk #(
  .ADDR_W(ADDR_W), .DEPTH(DEPTH), .BLOCK_BYTES(BLOCK_BYTES)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .miss_valid_i   (miss_valid_i),
  .miss_addr_i    (miss_addr_i),
  .alloc_o        (alloc_o),
  .alloc_addr_o   (alloc_addr_o),
  .alloc_stride_o (alloc_stride_o),
  .match_vec      (match_vec),
  .oldest_vec     (oldest_vec)
);

// File: tb/tb_stride_predictor.sv
module tb_stride_predictor;
  localparam int DEPTH = 10;
  localparam int BLK   = 32;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        miss_valid_i = 1'b0;
  logic [31:0] miss_pc_i = '0;
  logic [31:0] miss_addr_i = '0;
  logic        alloc_o;
  logic [31:0] alloc_addr_o;
  logic [31:0] alloc_stride_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  stride_predictor #(.PC_W(32), .ADDR_W(32), .DEPTH(DEPTH), .BLOCK_BYTES(BLK)) dut (
    .clk_i (clk), .rst_ni (rst_ni), .miss_valid_i (miss_valid_i),
    .miss_pc_i (miss_pc_i), .miss_addr_i (miss_addr_i),
    .alloc_o (alloc_o), .alloc_addr_o (alloc_addr_o), .alloc_stride_o (alloc_stride_o)
  );

  // reference model: keyed by PC, recency by timestamp
  bit          m_vld   [DEPTH];
  logic [31:0] m_pc    [DEPTH];
  logic [31:0] m_last  [DEPTH];
  logic [31:0] m_delta [DEPTH];
  int          m_cnt   [DEPTH];
  longint      m_time  [DEPTH];
  longint      now = 0;

  function automatic logic [31:0] clamp(logic [31:0] d);
    int s = int'(d);
    if (s > -BLK && s < BLK) return (s < 0) ? -BLK : BLK;
    return d;
  endfunction

  task automatic model_miss(input logic [31:0] pc, input logic [31:0] addr,
                            output bit e_alloc, output logic [31:0] e_addr,
                            output logic [31:0] e_str, output string tag);
    int idx = -1;
    logic [31:0] d;
    now++;
    for (int i = 0; i < DEPTH; i++) if (m_vld[i] && m_pc[i] == pc) idx = i;
    e_alloc = 0; e_addr = '0; e_str = '0;
    if (idx < 0) begin
      int v = -1;
      for (int i = 0; i < DEPTH; i++) if (!m_vld[i] && v < 0) v = i;
      if (v < 0) begin
        v = 0;
        for (int i = 1; i < DEPTH; i++) if (m_time[i] < m_time[v]) v = i;
      end
      m_vld[v] = 1; m_pc[v] = pc; m_last[v] = addr; m_cnt[v] = 1; m_time[v] = now;
      e_alloc = 1; e_str = BLK; e_addr = addr + BLK; tag = "R2";
    end else begin
      d = addr - m_last[idx];
      if (m_cnt[idx] == 1) begin
        tag = "R3";
        m_cnt[idx] = 2;
      end else begin
        tag = "R4";
        if (d == m_delta[idx]) begin
          e_alloc = 1; e_str = clamp(d); e_addr = addr + e_str;
        end
      end
      m_delta[idx] = d; m_last[idx] = addr; m_time[idx] = now;
    end
  endtask

  task automatic check_out(input string tag, input bit e_alloc,
                           input logic [31:0] e_addr, input logic [31:0] e_str);
    checks++;
    if (alloc_o !== e_alloc ||
        (e_alloc && (alloc_addr_o !== e_addr || alloc_stride_o !== e_str))) begin
      errors++;
      $display("FAIL %s: got alloc=%0b addr=%h stride=%h, expected alloc=%0b addr=%h stride=%h",
               tag, alloc_o, alloc_addr_o, alloc_stride_o, e_alloc, e_addr, e_str);
    end
  endtask

  // called at a negedge; returns at the following negedge after checking
  task automatic miss(input logic [31:0] pc, input logic [31:0] addr, input string note = "");
    bit e_a; logic [31:0] e_ad, e_s; string tag;
    model_miss(pc, addr, e_a, e_ad, e_s, tag);
    miss_valid_i = 1'b1; miss_pc_i = pc; miss_addr_i = addr;
    @(negedge clk);
    miss_valid_i = 1'b0;
    check_out((note != "") ? note : tag, e_a, e_ad, e_s);
  endtask

  task automatic idle(input string tag);
    miss_valid_i = 1'b0;
    miss_pc_i = $urandom;
    miss_addr_i = $urandom;
    @(negedge clk);
    check_out(tag, 1'b0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r_addr [12];
    int          r_str  [12];
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < DEPTH; i++) begin m_vld[i] = 0; m_time[i] = 0; end
    repeat (3) @(negedge clk);
    check_out("R1", 1'b0, '0, '0);
    rst_ni = 1'b1;
    @(negedge clk);
    check_out("R1", 1'b0, '0, '0);

    // R2/R3/R4 basic sequence, stride 64
    miss(32'h100, 32'h1000, "R2");
    miss(32'h100, 32'h1040, "R3");
    miss(32'h100, 32'h1080, "R4");
    miss(32'h100, 32'h10c8, "R4");
    idle("R8");
    // R5 small positive, negative, zero
    miss(32'h200, 32'h2000); miss(32'h200, 32'h2008); miss(32'h200, 32'h2010, "R5");
    miss(32'h300, 32'h3000); miss(32'h300, 32'h2ffc); miss(32'h300, 32'h2ff8, "R5");
    miss(32'h400, 32'h4000); miss(32'h400, 32'h4000); miss(32'h400, 32'h4000, "R5");
    miss(32'h500, 32'h5000); miss(32'h500, 32'h4f00); miss(32'h500, 32'h4e00, "R5");
    // R6 interleaved loads
    miss(32'h600, 32'h6000); miss(32'h700, 32'h7000);
    miss(32'h600, 32'h6080); miss(32'h700, 32'h6f80);
    miss(32'h600, 32'h6100, "R6"); miss(32'h700, 32'h6f00, "R6");
    idle("R8");
    // R7 eviction: flood with new PCs, then revisit
    for (int k = 0; k < DEPTH + 2; k++) miss(32'h9000 + 32'(k * 4), 32'h10000 + 32'(k * 256), "R7");
    miss(32'h9000, 32'h10100, "R7");
    miss(32'h9000 + 32'(DEPTH * 4 + 4), 32'h20000, "R7");

    // constrained random mix
    for (int i = 0; i < 12; i++) begin r_addr[i] = $urandom; r_str[i] = 64; end
    for (int n = 0; n < 4000; n++) begin
      int p = $urandom_range(11);
      if ($urandom_range(7) == 0) begin
        case ($urandom_range(7))
          0: r_str[p] = -64;  1: r_str[p] = -8;  2: r_str[p] = 0;  3: r_str[p] = 8;
          4: r_str[p] = 32;   5: r_str[p] = 96;  6: r_str[p] = -160; default: r_str[p] = 4096;
        endcase
      end
      r_addr[p] = r_addr[p] + 32'(r_str[p]);
      if ($urandom_range(15) == 0) idle("R8");
      miss(32'h4000_0000 + 32'(p * 16), r_addr[p]);
    end
    idle("R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule